// File: doc/BRIEF.md
# Supply-Watch Reset Timer

This block turns a digital "supply is good" level, coming from an external comparator, into a system reset. Whenever that level is low, the reset is driven active at once. Nothing depends on the clock for this. When the level returns, the reset is held until the level has stayed high for a fixed number of clock cycles. Only then is it released. A dip of any length during that wait starts the wait again from zero.

The reset leaves the block as a level together with an output enable, which models an open-drain pad. The enable is high only while the reset is active, so the pin is driven to its active level then and left floating otherwise. A build-time parameter picks an active-low or an active-high reset level. The wait length is a parameter in clock cycles. The default is 10,000,000 cycles, about 200 ms at 50 MHz, and it can be cut to a few cycles for simulation.

The controller has three states. ST_HOLD means the supply is bad and the counter is cleared. ST_COUNT means the supply is good and the time-out is running. ST_RUN means the reset is released. The transitions are as follows:
- ST_HOLD to ST_COUNT when the synchronised supply level reads high.
- ST_COUNT to ST_RUN when the counter reaches its last value.
- ST_COUNT to ST_HOLD, and ST_RUN to ST_HOLD, when the synchronised level reads low.

A low `supply_ok` also clears the state and the synchronizer asynchronously, so any state falls back to ST_HOLD with no clock edge.

Top module: `supply_reset_timer`

## Requirements
- R1: While `supply_ok` is low, `rst_oe` is 1 without waiting for a clock edge, and this holds in the reset state at time zero.
- R2: `supply_ok` passes through a chain of `SYNC_STAGES` flops, which are cleared asynchronously when it is low, before the controller sees it.
- R3: After `supply_ok` rises and stays high, the reset is released at exactly the clock edge numbered `SYNC_STAGES + 1 + HOLD_CYCLES`, counting the first edge that samples it high as edge 1.
- R4: A low pulse on `supply_ok` during the time-out restarts the count from zero, so the release again needs the full number of edges from R3.
- R5: Once released, the reset stays released for as long as `supply_ok` stays high.
- R6: With `ACTIVE_LOW = 1`, `rst_out` is 0 while reset is active and 1 otherwise. With `ACTIVE_LOW = 0`, `rst_out` is 1 while reset is active and 0 otherwise.
- R7: `rst_oe` is 1 exactly while reset is active and 0 once it is released (open-drain release).
- R8: The time-out counter never goes past `HOLD_CYCLES - 1`.
- R9: A drop of `supply_ok` after release asserts the reset again, and the next release needs the full count from R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| supply_ok | input | 1 | Asynchronous supply-good level from the comparator; low clears the block |
| rst_out | output | 1 | Reset level, polarity set by `ACTIVE_LOW` |
| rst_oe | output | 1 | Pad drive enable; 1 while reset is active |

## Verification
The bench drives `supply_ok` low for a single cycle partway through the time-out. A design that only paused the count, or that ignored short dips, would release too early. It checks the outputs one nanosecond after each falling supply edge. A design that took the dip through the synchronizer before asserting reset would show a late assertion. The bench compares the release cycle exactly against a count of consecutive good edges, which exposes an off-by-one in the counter limit or in the synchronizer depth. It also builds an active-high copy next to the active-low one, so that inverted polarity or an enable tied to the level cannot go unseen.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_RUN   = 2'd2
    } rst_state_e;
endpackage

// File: rtl/supply_sync.sv
module supply_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge async_in) begin
                    if (!async_in) chain_q[g] <= 1'b0;
                    else           chain_q[g] <= 1'b1;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge async_in) begin
                    if (!async_in) chain_q[g] <= 1'b0;
                    else           chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

    // R2: the synchronised level never falls while the raw level stays high
    assert_sync_monotonic_R2: assert property (@(posedge clk) disable iff (!async_in)
        sync_out |=> sync_out);
endmodule

// File: rtl/supply_timer.sv
module supply_timer #(
    parameter int LIMIT = 10
) (
    input  logic                       clk,
    input  logic                       clr_n,
    input  logic                       enable,
    output logic                       done,
    output logic [$clog2(LIMIT)-1:0]   count
);
    localparam int CNT_W = $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)                       cnt_q <= '0;
        else if (!enable)                 cnt_q <= '0;
        else if (cnt_q != LAST)           cnt_q <= cnt_q + 1'b1;
    end

    assign done  = enable && (cnt_q == LAST);
    assign count = cnt_q;

    // R8: counter stays inside its range
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!clr_n)
        cnt_q <= LAST);
endmodule

// File: rtl/supply_reset_timer.sv
module supply_reset_timer
    import supply_reset_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 10000000,
    parameter bit ACTIVE_LOW  = 1'b1
) (
    input  logic clk,
    input  logic supply_ok,
    output logic rst_out,
    output logic rst_oe
);
    localparam int CNT_W = $clog2(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);
    localparam logic ACT_LVL = ACTIVE_LOW ? 1'b0 : 1'b1;

    logic             ok_sync;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_count;
    rst_state_e       st_q, st_d;

    supply_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .async_in (supply_ok),
        .sync_out (ok_sync)
    );

    supply_timer #(.LIMIT(HOLD_CYCLES)) u_timer (
        .clk    (clk),
        .clr_n  (supply_ok),
        .enable (st_q == ST_COUNT),
        .done   (tmr_done),
        .count  (tmr_count)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD:  if (ok_sync)       st_d = ST_COUNT;
            ST_COUNT: if (!ok_sync)      st_d = ST_HOLD;
                      else if (tmr_done) st_d = ST_RUN;
            ST_RUN:   if (!ok_sync)      st_d = ST_HOLD;
            default:                     st_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) st_q <= ST_HOLD;
        else            st_q <= st_d;
    end

    always_comb begin
        rst_oe  = (st_q != ST_RUN);
        rst_out = rst_oe ? ACT_LVL : ~ACT_LVL;
    end

    // R1: a bad supply always shows as an active reset
    assert_prompt_assert_R1: assert property (@(posedge clk)
        !supply_ok |-> rst_oe);
    // R3: release only after the counter reached its last value
    assert_release_at_limit_R3: assert property (@(posedge clk) disable iff (!supply_ok)
        $fell(rst_oe) |-> $past(tmr_count) == LAST);
    // R5: once released, stays released while supply holds
    assert_stays_released_R5: assert property (@(posedge clk) disable iff (!supply_ok)
        !rst_oe |=> !rst_oe);
    // R4: the count starts from zero whenever counting begins
    assert_count_from_zero_R4: assert property (@(posedge clk) disable iff (!supply_ok)
        (st_q == ST_HOLD && ok_sync) |=> tmr_count == '0);
endmodule

// File: tb/test_supply_reset_timer.sv
module test_supply_reset_timer;
    localparam int S = 2;
    localparam int H = 12;
    localparam int RELEASE_AT = S + 1 + H;

    logic clk = 1'b0;
    logic supply_ok = 1'b0;
    logic lo_out, lo_oe, hi_out, hi_oe;
    int   n_checks = 0;
    int   n_fail = 0;
    int   ok_run = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    supply_reset_timer #(.SYNC_STAGES(S), .HOLD_CYCLES(H), .ACTIVE_LOW(1'b1)) i_supply_reset_timer (
        .clk(clk), .supply_ok(supply_ok), .rst_out(lo_out), .rst_oe(lo_oe));

    supply_reset_timer #(.SYNC_STAGES(S), .HOLD_CYCLES(H), .ACTIVE_LOW(1'b0)) i_supply_reset_timer_hi (
        .clk(clk), .supply_ok(supply_ok), .rst_out(hi_out), .rst_oe(hi_oe));

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b (good edges %0d)", tag, $time, act, exp, ok_run);
        end
    endtask

    task automatic compare_all(input string tag);
        logic exp_act;
        exp_act = (ok_run < RELEASE_AT);
        check(lo_oe,  exp_act,  {tag, " R7 oe"});
        check(hi_oe,  exp_act,  {tag, " R7 oe hi"});
        check(lo_out, ~exp_act, {tag, " R6 low polarity"});
        check(hi_out, exp_act,  {tag, " R6 high polarity"});
    endtask

    // one cycle: compare at negedge, drive, model at posedge
    task automatic step(input logic val, input string tag);
        @(negedge clk);
        compare_all(tag);
        supply_ok = val;
        if (!val) begin
            #1;
            check(lo_oe, 1'b1, {tag, " R1 prompt oe"});
            check(lo_out, 1'b0, {tag, " R1 prompt level"});
        end
        @(posedge clk);
        ok_run = supply_ok ? ok_run + 1 : 0;
    endtask

    initial begin
        #1;
        check(lo_oe, 1'b1, "R1 reset state oe");
        check(lo_out, 1'b0, "R1 reset state level");
        check(hi_out, 1'b1, "R6 reset state high level");
        for (int i = 0; i < 4; i++) step(1'b0, "R1 low");
        // R2 R3: full recovery, exact release edge
        for (int i = 0; i < RELEASE_AT + 6; i++) step(1'b1, "R3 first power-up");
        // R9: brownout after release, then full recount
        step(1'b0, "R9 brownout");
        step(1'b0, "R9 brownout");
        for (int i = 0; i < 8; i++) step(1'b1, "R9 recount");
        // R4: single-cycle dip mid-count restarts from zero
        step(1'b0, "R4 dip");
        for (int i = 0; i < RELEASE_AT + 4; i++) step(1'b1, "R4 restart");
        // R4: dip right before release
        step(1'b0, "R4 late dip");
        for (int i = 0; i < RELEASE_AT - 1; i++) step(1'b1, "R4 late count");
        step(1'b0, "R4 dip at last");
        for (int i = 0; i < RELEASE_AT + 3; i++) step(1'b1, "R3 final release");
        // R5: long stable supply keeps reset released
        for (int i = 0; i < 40; i++) step(1'b1, "R5 stable run");
        // R2: repeated short glitches never release
        for (int i = 0; i < 10; i++) begin
            step(1'b0, "R2 glitch low");
            step(1'b1, "R2 glitch high");
            step(1'b1, "R2 glitch high");
        end
        @(negedge clk);
        compare_all("R8 end");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule